// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen logical registers of a processor core together with the shadow copies that each execution mode keeps privately. It also holds the current status word and one saved status word for every privileged mode. The decode stage presents logical register numbers on two read ports and one write port. The block resolves each number to a physical copy through the mode field of the current status word. An optional user-bank override lets privileged code reach the user copies of the banked registers.

Exception entry and return are single-cycle status actions. On entry, the current status word is stored into the saved word of the target mode, the mode changes, and the interrupt masks are raised. On return, the status word is reloaded from the saved word of the current mode.

The status controller picks one action per cycle: HOLD, ENTER, RETURN or WRITE. The priority is ENTER, then RETURN, then WRITE. The mode field selects one of six banks: BK_USR, BK_FAST, BK_IRQ, BK_SUP, BK_ABT and BK_UND. Each transition between banks happens only through an ENTER, a RETURN, or a WRITE whose mode field is legal.

Top module: `bankreg_file`

## Requirements
- R1: After reset the status word is 0x000000D3 (supervisor mode, both interrupt masks set). Every register copy and every saved status word is zero.
- R2: The legal mode codes and their banks are: 10000 user (BK_USR), 10001 fast interrupt (BK_FAST), 10010 interrupt (BK_IRQ), 10011 supervisor (BK_SUP), 10111 abort (BK_ABT) and 11011 undefined (BK_UND). In user mode all sixteen logical registers address the user copies.
- R3: In fast-interrupt mode, registers 8 to 14 address private copies. Registers 0 to 7 and 15 address the user copies.
- R4: The interrupt, supervisor, abort and undefined modes each have private copies of registers 13 and 14. They share registers 0 to 12 and 15 with user mode.
- R5: The legacy codes 00000, 00001, 00010 and 00011 use the register bank and the saved status word of user, fast interrupt, interrupt and supervisor mode respectively.
- R6: Both read ports are combinational and independent. A write lands at the clock edge and becomes visible on the read ports from the following cycle.
- R7: The status word keeps only the flags N, Z, C and V in bits 31..28, the interrupt mask I in bit 7, the fast mask F in bit 6 and the mode in bits 4..0. All other bits read as zero.
- R8: A status write (WRITE) whose mode field is not a legal code leaves the mode unchanged but still updates the flags and the masks.
- R9: ENTER with a legal non-user target mode does three things. It copies the old status word into the target's saved word, sets the mode to the target, and sets I. It also sets F when the target is fast interrupt and otherwise keeps F. A user or illegal target is ignored.
- R10: RETURN reloads the status word from the saved word of the current mode, with the masking of R7 and R8 applied. In user mode a return request has no effect.
- R11: The saved-status output shows the saved word of the current mode, masked as in R7. In user mode it reads zero, and saved-status writes are ignored.
- R12: With the user-bank override set, reads and writes of registers 8 to 14 address the user copies in every mode. Registers 0 to 7 and 15 are unaffected by the override.
- R13: Only one status action takes effect per cycle. A legal ENTER beats RETURN, RETURN beats a status write, and a saved-status write is dropped in any cycle where ENTER or RETURN acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Logical register number, read port A |
| rd_a_data | output | DATA_W | Read data, port A |
| rd_b_idx | input | 4 | Logical register number, read port B |
| rd_b_data | output | DATA_W | Read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical register number to write |
| wr_data | input | DATA_W | Register write data |
| usr_bank | input | 1 | User-bank override for registers 8 to 14 |
| stat_wr_en | input | 1 | Status word write enable |
| stat_wr_data | input | 32 | New status word |
| saved_wr_en | input | 1 | Saved status word write enable (current mode) |
| saved_wr_data | input | 32 | New saved status word |
| trap_en | input | 1 | Exception entry request |
| trap_mode | input | 5 | Target mode of the exception entry |
| trap_ret | input | 1 | Exception return request |
| stat_out | output | 32 | Current status word |
| saved_out | output | 32 | Saved status word of the current mode |

## Verification
The bench builds the block with DATA_W set to 16. This keeps each written value small enough to encode both the writing mode and the register number. It then sweeps all ten legal mode codes, writing all sixteen registers in each mode. Every register is read back in every mode, with and without the override, on both ports, so every bank alias and every private copy is compared against a bench model of R2 to R5 and R12. Directed sequences drive chained exception entries and returns, illegal mode codes, user-mode saved-status accesses and simultaneous status requests. The status values expected for these are worked out from the bit fields.

// File: rtl/bankreg_pkg.sv
`timescale 1ns/1ps
package bankreg_pkg;

    // Architectural sizes
    localparam int unsigned NUM_LOG   = 16;
    localparam int unsigned IDX_W     = $clog2(NUM_LOG);
    localparam int unsigned PSR_W     = 32;
    localparam int unsigned MODE_W    = 5;

    // Banking boundaries (logical register numbers)
    localparam int unsigned FAST_LO   = 8;              // first register private to fast mode
    localparam int unsigned PRIV_LO   = 13;             // first register private to other modes
    localparam int unsigned PC_NUM    = NUM_LOG - 1;    // never banked
    localparam int unsigned FAST_CNT  = PC_NUM - FAST_LO;
    localparam int unsigned PRIV_CNT  = PC_NUM - PRIV_LO;
    localparam int unsigned NUM_PRIVB = 4;              // irq, sup, abt, und

    // Physical layout: user copies, then fast copies, then pairs
    localparam int unsigned FAST_BASE = NUM_LOG;
    localparam int unsigned PRIV_BASE = FAST_BASE + FAST_CNT;
    localparam int unsigned NUM_PHYS  = PRIV_BASE + NUM_PRIVB * PRIV_CNT;
    localparam int unsigned PHYS_W    = $clog2(NUM_PHYS);

    // Saved status slots: every bank except user
    localparam int unsigned NUM_SAVED = 1 + NUM_PRIVB;
    localparam int unsigned SLOT_W    = $clog2(NUM_SAVED);

    // Status word fields
    localparam int unsigned    BIT_I     = 7;
    localparam int unsigned    BIT_F     = 6;
    localparam logic [PSR_W-1:0] PSR_KEEP  = 32'hF000_00DF;
    localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

    // Mode codes
    localparam logic [MODE_W-1:0] MD_USR   = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FAST  = 5'b10001;
    localparam logic [MODE_W-1:0] MD_IRQ   = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SUP   = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABT   = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UND   = 5'b11011;
    localparam logic [MODE_W-1:0] MD26_USR = 5'b00000;
    localparam logic [MODE_W-1:0] MD26_FST = 5'b00001;
    localparam logic [MODE_W-1:0] MD26_IRQ = 5'b00010;
    localparam logic [MODE_W-1:0] MD26_SUP = 5'b00011;

    typedef enum logic [2:0] {
        BK_USR  = 3'd0,
        BK_FAST = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SUP  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5
    } bank_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_ENTER  = 2'd1,
        ACT_RETURN = 2'd2,
        ACT_WRITE  = 2'd3
    } stat_act_e;

    function automatic logic mode_ok(input logic [MODE_W-1:0] m);
        case (m)
            MD_USR, MD_FAST, MD_IRQ, MD_SUP, MD_ABT, MD_UND,
            MD26_USR, MD26_FST, MD26_IRQ, MD26_SUP: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    function automatic logic mode_is_user(input logic [MODE_W-1:0] m);
        return (m == MD_USR) || (m == MD26_USR);
    endfunction

    // Keep only defined fields; an illegal mode keeps the old one
    function automatic logic [PSR_W-1:0] psr_merge(input logic [PSR_W-1:0] old_w,
                                                   input logic [PSR_W-1:0] new_w);
        logic [PSR_W-1:0] r;
        r = new_w & PSR_KEEP;
        if (!mode_ok(new_w[MODE_W-1:0]))
            r[MODE_W-1:0] = old_w[MODE_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/bankreg_mode_dec.sv
`timescale 1ns/1ps
module bankreg_mode_dec
    import bankreg_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank,
    output logic              valid,
    output logic              is_user
);

    always_comb begin
        bank  = BK_USR;
        valid = 1'b1;
        unique case (mode)
            MD_USR,  MD26_USR: bank = BK_USR;
            MD_FAST, MD26_FST: bank = BK_FAST;
            MD_IRQ,  MD26_IRQ: bank = BK_IRQ;
            MD_SUP,  MD26_SUP: bank = BK_SUP;
            MD_ABT:            bank = BK_ABT;
            MD_UND:            bank = BK_UND;
            default: begin
                bank  = BK_USR;
                valid = 1'b0;
            end
        endcase
        is_user = valid && (bank == BK_USR);
    end

endmodule

// File: rtl/bankreg_gpr.sv
`timescale 1ns/1ps
module bankreg_gpr
    import bankreg_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM_RD = 2
)(
    input  logic                           clk,
    input  logic                           rst_n,
    input  bank_e                          bank,
    input  logic                           usr_ovr,
    input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_data
);

    localparam logic [IDX_W-1:0] R_FAST_LO = IDX_W'(FAST_LO);
    localparam logic [IDX_W-1:0] R_PRIV_LO = IDX_W'(PRIV_LO);
    localparam logic [IDX_W-1:0] R_PC      = IDX_W'(PC_NUM);

    // Logical number + bank -> physical copy
    function automatic logic [PHYS_W-1:0] phys_of(input logic [IDX_W-1:0] idx,
                                                  input bank_e           bk,
                                                  input logic            ovr);
        bank_e            eb;
        logic [PHYS_W-1:0] p;
        eb = ovr ? BK_USR : bk;
        p  = PHYS_W'(idx);
        unique case (eb)
            BK_USR: p = PHYS_W'(idx);
            BK_FAST: begin
                if (idx >= R_FAST_LO && idx < R_PC)
                    p = PHYS_W'(FAST_BASE) + PHYS_W'(idx - R_FAST_LO);
            end
            default: begin
                if (idx >= R_PRIV_LO && idx < R_PC)
                    p = PHYS_W'(PRIV_BASE)
                      + PHYS_W'(PRIV_CNT * (int'(eb) - int'(BK_IRQ)))
                      + PHYS_W'(idx - R_PRIV_LO);
            end
        endcase
        return p;
    endfunction

    logic [DATA_W-1:0] regs_q [NUM_PHYS];
    logic [PHYS_W-1:0] wr_p;

    assign wr_p = phys_of(wr_idx, bank, usr_ovr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++)
                regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[wr_p] <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        logic [PHYS_W-1:0] rp;
        assign rp         = phys_of(rd_idx[g], bank, usr_ovr);
        assign rd_data[g] = regs_q[rp];
    end

endmodule

// File: rtl/bankreg_status.sv
`timescale 1ns/1ps
module bankreg_status
    import bankreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             cur_bank,
    input  logic              cur_user,
    input  logic              stat_wr_en,
    input  logic [PSR_W-1:0]  stat_wr_data,
    input  logic              saved_wr_en,
    input  logic [PSR_W-1:0]  saved_wr_data,
    input  logic              trap_en,
    input  logic [MODE_W-1:0] trap_mode,
    input  logic              trap_ret,
    output logic [PSR_W-1:0]  stat,
    output logic [PSR_W-1:0]  saved_rd
);

    bank_e             trap_bank;
    logic              trap_valid;
    logic              trap_user;
    stat_act_e         act;
    logic [PSR_W-1:0]  stat_q, stat_d;
    logic [PSR_W-1:0]  saved_q [NUM_SAVED];
    logic [PSR_W-1:0]  saved_d [NUM_SAVED];
    logic [SLOT_W-1:0] cur_slot, trap_slot;

    bankreg_mode_dec u_trap_dec (
        .mode    (trap_mode),
        .bank    (trap_bank),
        .valid   (trap_valid),
        .is_user (trap_user)
    );

    assign cur_slot  = SLOT_W'(int'(cur_bank)  - 1);
    assign trap_slot = SLOT_W'(int'(trap_bank) - 1);

    // Action select: ENTER > RETURN > WRITE > HOLD
    always_comb begin
        act = ACT_HOLD;
        if (trap_en && trap_valid && !trap_user)
            act = ACT_ENTER;
        else if (trap_ret && !cur_user)
            act = ACT_RETURN;
        else if (stat_wr_en || (saved_wr_en && !cur_user))
            act = ACT_WRITE;
    end

    // Next-value process
    always_comb begin
        stat_d = stat_q;
        for (int i = 0; i < NUM_SAVED; i++)
            saved_d[i] = saved_q[i];
        unique case (act)
            ACT_ENTER: begin
                saved_d[trap_slot]    = stat_q;
                stat_d[MODE_W-1:0]    = trap_mode;
                stat_d[BIT_I]         = 1'b1;
                if (trap_bank == BK_FAST)
                    stat_d[BIT_F]     = 1'b1;
            end
            ACT_RETURN: begin
                stat_d = psr_merge(stat_q, saved_q[cur_slot]);
            end
            ACT_WRITE: begin
                if (stat_wr_en)
                    stat_d = psr_merge(stat_q, stat_wr_data);
                if (saved_wr_en && !cur_user)
                    saved_d[cur_slot] = saved_wr_data & PSR_KEEP;
            end
            default: begin
                stat_d = stat_q;
            end
        endcase
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= PSR_RESET;
            for (int i = 0; i < NUM_SAVED; i++)
                saved_q[i] <= '0;
        end else begin
            stat_q <= stat_d;
            for (int i = 0; i < NUM_SAVED; i++)
                saved_q[i] <= saved_d[i];
        end
    end

    assign stat     = stat_q;
    assign saved_rd = cur_user ? '0 : saved_q[cur_slot];

endmodule

// File: rtl/bankreg_file.sv
`timescale 1ns/1ps
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int unsigned DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              usr_bank,
    input  logic              stat_wr_en,
    input  logic [PSR_W-1:0]  stat_wr_data,
    input  logic              saved_wr_en,
    input  logic [PSR_W-1:0]  saved_wr_data,
    input  logic              trap_en,
    input  logic [MODE_W-1:0] trap_mode,
    input  logic              trap_ret,
    output logic [PSR_W-1:0]  stat_out,
    output logic [PSR_W-1:0]  saved_out
);

    localparam int unsigned NUM_RD = 2;

    logic [PSR_W-1:0]              stat_w;
    bank_e                         cur_bank;
    logic                          cur_valid;
    logic                          cur_user;
    logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data;

    bankreg_mode_dec u_cur_dec (
        .mode    (stat_w[MODE_W-1:0]),
        .bank    (cur_bank),
        .valid   (cur_valid),
        .is_user (cur_user)
    );

    bankreg_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .cur_bank      (cur_bank),
        .cur_user      (cur_user),
        .stat_wr_en    (stat_wr_en),
        .stat_wr_data  (stat_wr_data),
        .saved_wr_en   (saved_wr_en),
        .saved_wr_data (saved_wr_data),
        .trap_en       (trap_en),
        .trap_mode     (trap_mode),
        .trap_ret      (trap_ret),
        .stat          (stat_w),
        .saved_rd      (saved_out)
    );

    assign rd_idx = {rd_b_idx, rd_a_idx};

    bankreg_gpr #(
        .DATA_W (DATA_W),
        .NUM_RD (NUM_RD)
    ) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank    (cur_valid ? cur_bank : BK_USR),
        .usr_ovr (usr_bank),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign stat_out  = stat_w;

endmodule

// File: rtl/bankreg_file_chk.sv
`timescale 1ns/1ps
module bankreg_file_chk
    import bankreg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              stat_wr_en,
    input logic              trap_en,
    input logic [MODE_W-1:0] trap_mode,
    input logic              trap_ret,
    input logic [PSR_W-1:0]  stat_out,
    input logic [PSR_W-1:0]  saved_out
);

    a_r1_reset_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> stat_out == PSR_RESET);

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_out & ~PSR_KEEP) == '0);

    a_r8_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok(stat_out[MODE_W-1:0]));

    a_r9_entry_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_en && mode_ok(trap_mode) && !mode_is_user(trap_mode))
        |=> (stat_out[MODE_W-1:0] == $past(trap_mode)) && stat_out[BIT_I]);

    a_r9_entry_fast_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_en && (trap_mode == MD_FAST || trap_mode == MD26_FST)) |=> stat_out[BIT_F]);

    a_r10_user_return: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ret && !trap_en && !stat_wr_en && mode_is_user(stat_out[MODE_W-1:0]))
        |=> $stable(stat_out));

    a_r11_user_saved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mode_is_user(stat_out[MODE_W-1:0]) |-> saved_out == '0);

endmodule

bind bankreg_file bankreg_file_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_wr_en (stat_wr_en),
    .trap_en    (trap_en),
    .trap_mode  (trap_mode),
    .trap_ret   (trap_ret),
    .stat_out   (stat_out),
    .saved_out  (saved_out)
);

// File: tb/bankreg_file_test.sv
`timescale 1ns/1ps
module bankreg_file_test;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, usr_bank = 1'b0;
    logic          stat_wr_en = 1'b0, saved_wr_en = 1'b0;
    logic [31:0]   stat_wr_data = '0, saved_wr_data = '0;
    logic          trap_en = 1'b0, trap_ret = 1'b0;
    logic [4:0]    trap_mode = '0;
    logic [31:0]   stat_out, saved_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bankreg_file #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .usr_bank(usr_bank),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data),
        .trap_en(trap_en), .trap_mode(trap_mode), .trap_ret(trap_ret),
        .stat_out(stat_out), .saved_out(saved_out)
    );

    // Bench model of register copies
    logic [DW-1:0] m_usr  [16];
    logic [DW-1:0] m_fast [7];
    logic [DW-1:0] m_prv  [4][2];

    logic [4:0] modes [10] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17,
                               5'h1B, 5'h00, 5'h01, 5'h02, 5'h03};

    function automatic int bank_of(input logic [4:0] m);
        case (m)
            5'h10, 5'h00: return 0;
            5'h11, 5'h01: return 1;
            5'h12, 5'h02: return 2;
            5'h13, 5'h03: return 3;
            5'h17:        return 4;
            5'h1B:        return 5;
            default:      return -1;
        endcase
    endfunction

    function automatic logic [DW-1:0] m_rd(input int b, input int i, input bit ovr);
        if (ovr && i >= 8 && i <= 14) return m_usr[i];
        if (b == 1 && i >= 8 && i <= 14) return m_fast[i-8];
        if (b >= 2 && (i == 13 || i == 14)) return m_prv[b-2][i-13];
        return m_usr[i];
    endfunction

    task automatic m_wr(input int b, input int i, input bit ovr, input logic [DW-1:0] v);
        if (ovr && i >= 8 && i <= 14) m_usr[i] = v;
        else if (b == 1 && i >= 8 && i <= 14) m_fast[i-8] = v;
        else if (b >= 2 && (i == 13 || i == 14)) m_prv[b-2][i-13] = v;
        else m_usr[i] = v;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic stat_write(input logic [31:0] v);
        stat_wr_en = 1'b1; stat_wr_data = v;
        tick();
        stat_wr_en = 1'b0;
        #1;
    endtask

    task automatic reg_write(input int i, input bit ovr, input logic [DW-1:0] v);
        wr_en = 1'b1; wr_idx = 4'(i); wr_data = v; usr_bank = ovr;
        tick();
        wr_en = 1'b0; usr_bank = 1'b0;
        #1;
    endtask

    task automatic trap(input logic [4:0] m);
        trap_en = 1'b1; trap_mode = m;
        tick();
        trap_en = 1'b0;
        #1;
    endtask

    task automatic ret();
        trap_ret = 1'b1;
        tick();
        trap_ret = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_usr[i] = '0;
        for (int i = 0; i < 7; i++) m_fast[i] = '0;
        for (int b = 0; b < 4; b++) for (int i = 0; i < 2; i++) m_prv[b][i] = '0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;

        // R1: reset state
        chk("R1 status", stat_out, 32'h0000_00D3);
        chk("R1 saved", saved_out, 32'h0);
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i); #1;
            chk("R1 reg", 32'(rd_a_data), 32'h0);
        end

        // R6: write visible only after the edge
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 16'h1234; rd_a_idx = 4'd3;
        #1 chk("R6 before edge", 32'(rd_a_data), 32'h0);
        tick();
        wr_en = 1'b0;
        #1 chk("R6 after edge", 32'(rd_a_data), 32'h1234);
        m_wr(3, 3, 1'b0, 16'h1234);

        // Fill every register in every mode
        for (int mi = 0; mi < 10; mi++) begin
            stat_write(32'h0000_00C0 | 32'(modes[mi]));
            for (int i = 0; i < 16; i++) begin
                logic [DW-1:0] v;
                v = {4'(mi), 4'(i), 8'h5A};
                reg_write(i, 1'b0, v);
                m_wr(bank_of(modes[mi]), i, 1'b0, v);
            end
        end

        // R12: override writes from privileged modes
        stat_write(32'h0000_00D1);
        reg_write(9, 1'b1, 16'hBEEF);  m_wr(1, 9, 1'b1, 16'hBEEF);
        reg_write(5, 1'b1, 16'hC0DE);  m_wr(1, 5, 1'b1, 16'hC0DE);
        stat_write(32'h0000_00DB);
        reg_write(14, 1'b1, 16'hFACE); m_wr(5, 14, 1'b1, 16'hFACE);
        reg_write(13, 1'b0, 16'hD00D); m_wr(5, 13, 1'b0, 16'hD00D);

        // Read sweep: every mode, both override settings, both ports
        for (int mi = 0; mi < 10; mi++) begin
            int b;
            b = bank_of(modes[mi]);
            stat_write(32'h0000_00C0 | 32'(modes[mi]));
            for (int ov = 0; ov < 2; ov++) begin
                for (int i = 0; i < 16; i++) begin
                    string tag;
                    usr_bank = ov[0]; rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
                    #1;
                    if (ov == 1 && i >= 8 && i <= 14) tag = "R12";
                    else if (mi >= 6) tag = "R5";
                    else if (b == 0) tag = "R2";
                    else if (b == 1) tag = "R3";
                    else tag = "R4";
                    chk(tag, 32'(rd_a_data), 32'(m_rd(b, i, ov[0])));
                    chk("R6 port b", 32'(rd_b_data), 32'(m_rd(b, 15 - i, ov[0])));
                end
            end
            usr_bank = 1'b0;
        end

        // R7 / R8: field masking and illegal modes
        stat_write(32'hAFFF_FFD2);
        chk("R7 mask", stat_out, 32'hA000_00D2);
        stat_write(32'h5000_001F);
        chk("R8 illegal mode", stat_out, 32'h5000_0012);
        stat_write(32'h0000_00D4);
        chk("R8 illegal mode 10100", stat_out, 32'h0000_00D2);

        // R9: entry and chained entry
        stat_write(32'h1000_0013);
        trap(5'b10001);
        chk("R9 enter fast", stat_out, 32'h1000_00D1);
        chk("R9 saved fast", saved_out, 32'h1000_0013);
        trap(5'b10010);
        chk("R9 enter irq", stat_out, 32'h1000_00D2);
        chk("R9 saved irq", saved_out, 32'h1000_00D1);

        // R10: returns unwind
        ret();
        chk("R10 return to fast", stat_out, 32'h1000_00D1);
        chk("R10 fast saved kept", saved_out, 32'h1000_0013);
        ret();
        chk("R10 return to sup", stat_out, 32'h1000_0013);

        // R9: user or illegal targets ignored
        trap(5'b10000);
        chk("R9 user target ignored", stat_out, 32'h1000_0013);
        trap(5'b11111);
        chk("R9 illegal target ignored", stat_out, 32'h1000_0013);
        trap(5'b10010);
        chk("R9 F kept on irq entry", stat_out, 32'h1000_0092);

        // R11: saved write in privileged mode, masked
        saved_wr_en = 1'b1; saved_wr_data = 32'h2FFF_FF11;
        tick(); saved_wr_en = 1'b0; #1;
        chk("R11 saved write", saved_out, 32'h2000_0011);
        ret();
        chk("R10 restore written word", stat_out, 32'h2000_0011);

        // R11 / R10: user mode
        stat_write(32'h0000_0010);
        chk("R11 user saved zero", saved_out, 32'h0);
        saved_wr_en = 1'b1; saved_wr_data = 32'hF000_00D3;
        tick(); saved_wr_en = 1'b0; #1;
        chk("R11 user saved write ignored", saved_out, 32'h0);
        ret();
        chk("R10 user return ignored", stat_out, 32'h0000_0010);
        stat_write(32'h0000_0012);
        chk("R11 irq saved untouched", saved_out, 32'h2000_0011);
        stat_write(32'h0000_0002);
        chk("R5 legacy irq shares saved", saved_out, 32'h2000_0011);

        // R13: priorities
        trap_en = 1'b1; trap_mode = 5'b10011;
        stat_wr_en = 1'b1; stat_wr_data = 32'hF000_0010;
        tick(); trap_en = 1'b0; stat_wr_en = 1'b0; #1;
        chk("R13 entry beats write", stat_out, 32'h0000_0093);
        chk("R13 saved sup", saved_out, 32'h0000_0002);
        trap_ret = 1'b1; stat_wr_en = 1'b1; stat_wr_data = 32'hF000_0017;
        tick(); trap_ret = 1'b0; stat_wr_en = 1'b0; #1;
        chk("R13 return beats write", stat_out, 32'h0000_0002);
        trap_ret = 1'b1; saved_wr_en = 1'b1; saved_wr_data = 32'h4000_0013;
        tick(); trap_ret = 1'b0; saved_wr_en = 1'b0; #1;
        chk("R13 return in legacy irq", stat_out, 32'h2000_0011);
        stat_write(32'h0000_0012);
        chk("R13 saved write dropped", saved_out, 32'h2000_0011);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule